// File: doc/BRIEF.md
# Indirect Dword Select Register Window

This block places a small index/data window in a device's configuration space. Through it, software reaches a register file that is too large to map directly. The window spans two dwords. The first dword holds a select byte, which names one dword of the register file, and a read-only status byte. The second dword is a 32-bit data register that stands in for the selected register-file dword.

Software writes the select byte, then reads or writes the data register. A write that touches the data bytes first merges into the data register under its byte enables. The merged dword is then pushed to the register file at byte address select × 4. After any accepted write to the window, the data register is refilled from the register file, so the next read shows current contents.

Register-file dwords at or beyond the configured size behave as absent: they read as zero and writes to them never leave the block. A `ready` output is low while the push and refill are in progress. Writes presented while `ready` is low are discarded.

Top module: `idxwin_window`

## Requirements
- R1: After reset the select byte, the data register and the status byte are all zero, `ready` is high and `rf_wr_en` is low.
- R2: On the window's first dword (dword address `WIN_DW`), byte lane 2 (bits 23:16) writes the select byte, and a read returns it there. Bits 31:24 (status) and bits 15:0 of that dword always read zero.
- R3: A write to the window's second dword (`WIN_DW+1`) merges into the data register: each byte lane whose enable is set takes the new byte, and every other lane keeps its old byte.
- R4: The cycle after an accepted data-dword write, `rf_wr_en` is high for exactly one cycle. In that cycle `rf_addr` equals select × 4 and `rf_wdata` equals the merged 32-bit value.
- R5: After any accepted write with a nonzero byte enable to either window dword, the data register is reloaded from `rf_rdata` at select × 4. `ready` is low for exactly two cycles after a data-dword write and exactly one cycle after a first-dword-only write.
- R6: Writes to any other dword address, or writes with all byte enables clear, change no state, keep `ready` high and cause no register-file write.
- R7: When the select value is at least `RF_DWORDS`, `rf_wr_en` stays low and the reload places zero in the data register.
- R8: A write presented while `ready` is low is dropped entirely.
- R9: Reads of any configuration dword outside the window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration write dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_addr | input | CFG_AW | Configuration read dword address |
| cfg_rdata | output | 32 | Read data, combinational from `cfg_rd_addr` |
| ready | output | 1 | High when a new write will be accepted |
| rf_wr_en | output | 1 | Register-file dword write strobe |
| rf_addr | output | 10 | Register-file byte address (select × 4) |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data for `rf_addr` |

## Verification
A corrupted select byte shows up at once on `rf_addr` and in the first window dword read. It also sends the next forwarded write and refill to the wrong register-file dword, so the following data read disagrees with the bench's model of the file. A stuck or skipped phase shows within two cycles as a wrong count of low `ready` cycles, or as a missing or doubled `rf_wr_en` pulse. A bad lane merge or a missed out-of-range guard shows in the very next forwarded data word or data read.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

    localparam int SEL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int SEL_LANE = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PUSH = 2'd1,
        PH_PULL = 2'd2
    } phase_e;

endpackage

// File: rtl/idxwin_decode.sv
module idxwin_decode #(
    parameter int CFG_AW = 6,
    parameter int WIN_DW = 16
) (
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [3:0]        be,
    output logic              hit_any,
    output logic              hit_ctl,
    output logic              hit_data,
    output logic              sel_lane
);
    localparam logic [CFG_AW-1:0] CTL_A  = CFG_AW'(WIN_DW);
    localparam logic [CFG_AW-1:0] DATA_A = CFG_AW'(WIN_DW + 1);

    logic live;

    always_comb begin
        live     = wr_en && (be != 4'b0000);
        hit_ctl  = live && (wr_addr == CTL_A);
        hit_data = live && (wr_addr == DATA_A);
        hit_any  = hit_ctl || hit_data;
        sel_lane = hit_ctl && be[idxwin_pkg::SEL_LANE];
    end
endmodule

// File: rtl/idxwin_merge.sv
module idxwin_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] old_word,
    input  logic [LANES*8-1:0] new_word,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? new_word[g*8 +: 8]
                                             : old_word[g*8 +: 8];
    end
endmodule

// File: rtl/idxwin_rdmux.sv
module idxwin_rdmux #(
    parameter int CFG_AW = 6,
    parameter int WIN_DW = 16
) (
    input  logic [CFG_AW-1:0] rd_addr,
    input  logic [7:0]        sel,
    input  logic [31:0]       data,
    output logic [31:0]       rdata
);
    localparam logic [CFG_AW-1:0] CTL_A  = CFG_AW'(WIN_DW);
    localparam logic [CFG_AW-1:0] DATA_A = CFG_AW'(WIN_DW + 1);

    always_comb begin
        rdata = '0;
        if (rd_addr == CTL_A) begin
            rdata = {8'h00, sel, 16'h0000};
        end else if (rd_addr == DATA_A) begin
            rdata = data;
        end
    end
endmodule

// File: rtl/idxwin_window.sv
module idxwin_window #(
    parameter int CFG_AW    = 6,
    parameter int WIN_DW    = 16,
    parameter int RF_DWORDS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic [CFG_AW-1:0] cfg_rd_addr,
    output logic [31:0]       cfg_rdata,
    output logic              ready,
    output logic              rf_wr_en,
    output logic [9:0]        rf_addr,
    output logic [31:0]       rf_wdata,
    input  logic [31:0]       rf_rdata
);
    import idxwin_pkg::*;

    localparam int RF_AW = SEL_W + 2;

    typedef struct packed {
        phase_e             phase;
        logic [SEL_W-1:0]   sel;
        logic [DATA_W-1:0]  data;
    } win_state_t;

    win_state_t st_q, st_d;

    logic              hit_any, hit_ctl, hit_data, sel_lane;
    logic [DATA_W-1:0] merged;
    logic              in_range;
    logic              accept;

    idxwin_decode #(.CFG_AW(CFG_AW), .WIN_DW(WIN_DW)) u_dec (
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .be       (cfg_be),
        .hit_any  (hit_any),
        .hit_ctl  (hit_ctl),
        .hit_data (hit_data),
        .sel_lane (sel_lane)
    );

    idxwin_merge #(.LANES(LANES)) u_merge (
        .old_word (st_q.data),
        .new_word (cfg_wdata),
        .lane_en  (cfg_be),
        .merged   (merged)
    );

    idxwin_rdmux #(.CFG_AW(CFG_AW), .WIN_DW(WIN_DW)) u_rd (
        .rd_addr (cfg_rd_addr),
        .sel     (st_q.sel),
        .data    (st_q.data),
        .rdata   (cfg_rdata)
    );

    always_comb begin
        in_range = int'(st_q.sel) < RF_DWORDS;
        accept   = (st_q.phase == PH_IDLE) && hit_any;
        st_d     = st_q;
        rf_wr_en = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (sel_lane) begin
                        st_d.sel = cfg_wdata[SEL_LANE*8 +: 8];
                    end
                    if (hit_data) begin
                        st_d.data  = merged;
                        st_d.phase = PH_PUSH;
                    end else begin
                        st_d.phase = PH_PULL;
                    end
                end
            end
            PH_PUSH: begin
                rf_wr_en   = in_range;
                st_d.phase = PH_PULL;
            end
            PH_PULL: begin
                st_d.data  = in_range ? rf_rdata : '0;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sel: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready    = (st_q.phase == PH_IDLE);
    assign rf_addr  = RF_AW'({st_q.sel, 2'b00});
    assign rf_wdata = st_q.data;

endmodule

// File: rtl/idxwin_checker.sv
module idxwin_checker #(
    parameter int CFG_AW    = 6,
    parameter int WIN_DW    = 16,
    parameter int RF_DWORDS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_wr_addr,
    input logic [3:0]        cfg_be,
    input logic              ready,
    input logic              rf_wr_en,
    input logic [9:0]        rf_addr
);
    localparam logic [CFG_AW-1:0] A0 = CFG_AW'(WIN_DW);
    localparam logic [CFG_AW-1:0] A1 = CFG_AW'(WIN_DW + 1);

    logic win_wr, data_wr, other_wr;
    assign win_wr   = cfg_wr_en && ready && (cfg_be != 4'b0000) &&
                      ((cfg_wr_addr == A0) || (cfg_wr_addr == A1));
    assign data_wr  = win_wr && (cfg_wr_addr == A1);
    assign other_wr = cfg_wr_en && ready && !win_wr;

    // R7: no register-file write leaves the block for an absent dword
    p_rf_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (int'(rf_addr) < RF_DWORDS * 4));

    // R4: the forward strobe lasts one cycle
    p_single_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    // R4: a push is never issued while idle
    p_push_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !ready);

    // R5: an accepted window write makes the block busy
    p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |=> !ready);

    // R5: a data write is still busy in its second cycle
    p_two_cycles_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> ##1 !ready);

    // R6: a write outside the window leaves the block idle and the select alone
    p_ignore_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> (ready && $stable(rf_addr)));

    // R8: the select cannot move while busy
    p_sel_held_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(rf_addr));
endmodule

bind idxwin_window idxwin_checker #(
    .CFG_AW(CFG_AW), .WIN_DW(WIN_DW), .RF_DWORDS(RF_DWORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_be(cfg_be), .ready(ready), .rf_wr_en(rf_wr_en), .rf_addr(rf_addr)
);

// File: tb/idxwin_window_test.sv
`timescale 1ns/1ps
module idxwin_window_test;
    localparam int CFG_AW = 6;
    localparam int WIN_DW = 16;
    localparam int NDW    = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [CFG_AW-1:0] cfg_wr_addr = '0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [CFG_AW-1:0] cfg_rd_addr = '0;
    logic [31:0]       cfg_rdata;
    logic              ready;
    logic              rf_wr_en;
    logic [9:0]        rf_addr;
    logic [31:0]       rf_wdata;
    logic [31:0]       rf_rdata;

    logic [31:0] mem [NDW];
    int          wr_count = 0;
    logic [9:0]  last_addr = '0;
    logic [31:0] last_data = '0;
    int          n_vec = 0;
    int          n_bad = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    idxwin_window #(.CFG_AW(CFG_AW), .WIN_DW(WIN_DW), .RF_DWORDS(NDW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rdata(cfg_rdata), .ready(ready), .rf_wr_en(rf_wr_en),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = (int'(rf_addr[9:2]) < NDW) ? mem[rf_addr[9:2]] : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (rf_wr_en) begin
            wr_count  = wr_count + 1;
            last_addr = rf_addr;
            last_data = rf_wdata;
            if (int'(rf_addr[9:2]) < NDW) mem[rf_addr[9:2]] = rf_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            report();
        end
    end

    task automatic cfg_wr(input logic [CFG_AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [CFG_AW-1:0] a, output logic [31:0] v);
        cfg_rd_addr = a;
        #0.5;
        v = cfg_rdata;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = be[k] ? n[k*8 +: 8] : o[k*8 +: 8];
        return r;
    endfunction

    initial begin
        logic [31:0] v, exp, prev, w;
        int busy, wc;
        for (int i = 0; i < NDW; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ready", {31'b0, ready}, 32'd1);
        check("R1 rf_wr_en", {31'b0, rf_wr_en}, 32'd0);
        rd(CFG_AW'(WIN_DW), v);     check("R1 select/status", v, 32'h0);
        rd(CFG_AW'(WIN_DW + 1), v); check("R1 data", v, 32'h0);

        // Sweep every select value past the end of the file
        for (int s = 0; s < NDW + 4; s++) begin
            cfg_wr(CFG_AW'(WIN_DW), 4'b0100, 32'hFFFF_FFFF & {8'hEE, 8'(s), 16'hBEEF});
            wait_idle(busy);
            check("R5 busy cycles after select write", 32'(busy), 32'd1);
            rd(CFG_AW'(WIN_DW), v);
            check("R2 select readback", v, {8'h00, 8'(s), 16'h0000});
            rd(CFG_AW'(WIN_DW + 1), v);
            exp = (s < NDW) ? mem[s] : 32'h0;
            check((s < NDW) ? "R5 reload on select" : "R7 absent reads zero", v, exp);

            wc = wr_count;
            w  = 32'h1000_0000 + s * 32'h0001_0203;
            cfg_wr(CFG_AW'(WIN_DW + 1), 4'b1111, w);
            wait_idle(busy);
            check("R5 busy cycles after data write", 32'(busy), 32'd2);
            if (s < NDW) begin
                check("R4 one forward", 32'(wr_count - wc), 32'd1);
                check("R4 forward address", {22'b0, last_addr}, 32'(s * 4));
                check("R4 forward data", last_data, w);
                rd(CFG_AW'(WIN_DW + 1), v);
                check("R5 data after reload", v, w);
            end else begin
                check("R7 no forward", 32'(wr_count - wc), 32'd0);
                rd(CFG_AW'(WIN_DW + 1), v);
                check("R7 reload zero", v, 32'h0);
            end

            if (s == 0 || s == 7 || s == NDW - 1) begin
                prev = w;
                for (int be = 1; be < 16; be++) begin
                    w = ~prev ^ (be * 32'h1357_9BDF);
                    cfg_wr(CFG_AW'(WIN_DW + 1), 4'(be), w);
                    wait_idle(busy);
                    exp = merge(prev, w, 4'(be));
                    check("R3 merged forward", last_data, exp);
                    rd(CFG_AW'(WIN_DW + 1), v);
                    check("R3 merged readback", v, exp);
                    prev = exp;
                end
            end
        end

        // R6: writes outside the window, or with no enables, do nothing
        cfg_wr(CFG_AW'(WIN_DW), 4'b0100, 32'h0003_0000);
        wait_idle(busy);
        rd(CFG_AW'(WIN_DW + 1), prev);
        for (int t = 0; t < 3; t++) begin
            wc = wr_count;
            if (t == 0) cfg_wr(CFG_AW'(WIN_DW + 2), 4'b1111, 32'h0909_0909);
            if (t == 1) cfg_wr(CFG_AW'(WIN_DW - 1), 4'b1111, 32'h0909_0909);
            if (t == 2) cfg_wr(CFG_AW'(WIN_DW + 1), 4'b0000, 32'h0909_0909);
            check("R6 ready stays high", {31'b0, ready}, 32'd1);
            check("R6 no forward", 32'(wr_count - wc), 32'd0);
            rd(CFG_AW'(WIN_DW), v);     check("R6 select kept", v, 32'h0003_0000);
            rd(CFG_AW'(WIN_DW + 1), v); check("R6 data kept", v, prev);
        end

        // R9: reads outside the window
        rd(CFG_AW'(WIN_DW + 2), v); check("R9 read outside", v, 32'h0);
        rd(CFG_AW'(0), v);          check("R9 read outside", v, 32'h0);

        // R5: file change seen only after a window write
        mem[3] = 32'h7777_1234;
        rd(CFG_AW'(WIN_DW + 1), v); check("R5 no reload without write", v, prev);
        cfg_wr(CFG_AW'(WIN_DW), 4'b0001, 32'h0000_00FF);
        wait_idle(busy);
        check("R5 header write busy", 32'(busy), 32'd1);
        rd(CFG_AW'(WIN_DW), v);     check("R2 header lanes read zero", v, 32'h0003_0000);
        rd(CFG_AW'(WIN_DW + 1), v); check("R5 reload after header write", v, 32'h7777_1234);

        // R8: write during busy is dropped
        wc = wr_count;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = CFG_AW'(WIN_DW + 1); cfg_be = 4'b1111; cfg_wdata = 32'h2468_ACE0;
        @(negedge clk);
        cfg_wr_addr = CFG_AW'(WIN_DW); cfg_be = 4'b0100; cfg_wdata = 32'h000B_0000;
        @(negedge clk);
        cfg_wr_addr = CFG_AW'(WIN_DW + 1); cfg_be = 4'b1111; cfg_wdata = 32'h1111_1111;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
        wait_idle(busy);
        check("R8 one forward only", 32'(wr_count - wc), 32'd1);
        rd(CFG_AW'(WIN_DW), v);     check("R8 select unchanged", v, 32'h0003_0000);
        rd(CFG_AW'(WIN_DW + 1), v); check("R8 data unchanged", v, 32'h2468_ACE0);
        check("R8 file holds first write", mem[3], 32'h2468_ACE0);

        done = 1'b1;
        report();
    end
endmodule